// File: doc/BRIEF.md
# False-Carrier Disconnect Monitor

This block watches the carrier events seen on one 100 Mb/s repeater port and decides when the port must be cut off from the MII. For every carrier it is told when the carrier starts, whether the start delimiter pair arrived intact, and how long the carrier stays up. Durations are measured in bit times by counting a bit-time tick input. A separate pulse reports each frame that completed without error.

A carrier whose delimiter is wrong is a false carrier. Every false carrier adds one to an 8-bit saturating counter. Two long false carriers in a row, with no good frame between them, isolate the port. The port comes back when it sees either a long enough good carrier or a long stretch of continuous idle. Any disconnect also sets a sticky flag.

Software reads a 16-bit status word that holds the flag and the counter. The read clears both. The monitor does anything only when the port is in repeater mode, running at 100 Mb/s, and the disconnect feature is enabled.

Top module: `fcm_mon`

## Requirements
- R1: While active, each carrier start (`carrier_start_i`=1) with `delim_ok_i`=0 is a false carrier and adds one to the counter. A start with `delim_ok_i`=1 adds nothing.
- R2: The port becomes isolated (`isolated_o`=1) at the end of the second qualifying false carrier when no good frame came after the first. A short false carrier neither counts toward isolation nor breaks the pair.
- R3: The duration of a carrier is the number of bit ticks seen while `carrier_i` is high, counting from the cycle after the start. A false carrier qualifies only if its duration is more than 480.
- R4: A `frame_good_i` pulse discards a pending first qualifying false carrier.
- R5: An isolated port reconnects at the end of a good-delimiter carrier whose duration is at least 480. A shorter good carrier leaves the port isolated.
- R6: An isolated port reconnects once 28000 bit ticks have been counted with `carrier_i` low, without a break.
- R7: A read pulse on `rd_i` loads `rd_data_o` on the next clock edge. The layout is bit 15 = disconnect flag, bits 14:8 = 0, bits 7:0 = counter.
- R8: A read clears the counter and the flag. A false carrier or a disconnect in the same cycle as the read is left out of the returned word and recorded after the clear.
- R9: The counter saturates at 255 and does not wrap.
- R10: The disconnect flag is set by every disconnect and stays set until a read.
- R11: The block is active only when `rep_mode_i`, `speed100_i` and `disc_en_i` are all 1. While it is inactive, nothing is counted, no pending strike is kept, and `isolated_o` is driven low.
- R12: After reset, `isolated_o` is 0 and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rep_mode_i | input | 1 | Port is in repeater mode |
| speed100_i | input | 1 | Port runs at 100 Mb/s |
| disc_en_i | input | 1 | Disconnect feature enable |
| bit_tick_i | input | 1 | One pulse per bit time |
| carrier_i | input | 1 | Carrier present |
| carrier_start_i | input | 1 | First cycle of a carrier |
| delim_ok_i | input | 1 | Start delimiter pair received correctly (valid with carrier_start_i) |
| frame_good_i | input | 1 | A good frame completed |
| rd_i | input | 1 | Status word read strobe |
| rd_data_o | output | 16 | Status word: flag, zeros, counter |
| isolated_o | output | 1 | Port is cut off from the MII |

## Verification
The assertions run on every cycle and cover the following:
- isolation only ever begins right after a carrier ends;
- an inactive configuration forces the port to stay connected;
- outside of reads, the counter never decreases and never steps by more than one;
- a read returns exactly the state held before it and leaves at most the same-cycle event behind;
- the flag survives every cycle that has no read.

Only the bench scenarios can show the rest:
- the duration boundaries at 480 and 481 ticks;
- the two-strike rule, including a good frame or a short false carrier between the strikes;
- reconnection by a good carrier or by a 28000-tick idle;
- saturation of the counter at 255.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PAD_W  = WORD_W - 1 - CNT_W;

  typedef struct packed {
    logic             disc;
    logic [PAD_W-1:0] pad;
    logic [CNT_W-1:0] cnt;
  } stat_word_t;
endpackage

// File: rtl/fcm_sat_timer.sv
module fcm_sat_timer #(
  parameter int unsigned MAX = 481,
  localparam int unsigned W  = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_o <= '0;
    else if (clr_i)                        cnt_o <= '0;
    else if (inc_i && cnt_o != W'(MAX))    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fcm_link_ctl.sv
module fcm_link_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic qual_false_i,
  input  logic qual_good_i,
  input  logic idle_done_i,
  input  logic frame_good_i,
  output logic isolated_o,
  output logic disc_evt_o
);
  logic strike_q;
  logic reconn;

  assign disc_evt_o = active_i && !isolated_o && qual_false_i && strike_q;
  assign reconn     = active_i && isolated_o && (qual_good_i || idle_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isolated_o <= 1'b0;
      strike_q   <= 1'b0;
    end else if (!active_i) begin
      isolated_o <= 1'b0;
      strike_q   <= 1'b0;
    end else if (disc_evt_o) begin
      isolated_o <= 1'b1;
      strike_q   <= 1'b0;
    end else if (reconn) begin
      isolated_o <= 1'b0;
      strike_q   <= 1'b0;
    end else if (frame_good_i) begin
      strike_q   <= 1'b0;
    end else if (qual_false_i && !isolated_o) begin
      strike_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/fcm_stat_reg.sv
module fcm_stat_reg
  import fcm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_evt_i,
  input  logic              disc_evt_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              sticky_o
);
  stat_word_t word_q;

  assign rd_data_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      sticky_o <= 1'b0;
      word_q   <= '0;
    end else if (rd_i) begin
      word_q.disc <= sticky_o;
      word_q.pad  <= '0;
      word_q.cnt  <= cnt_o;
      // same-cycle events survive the clear
      cnt_o       <= count_evt_i ? CNT_W'(1) : '0;
      sticky_o    <= disc_evt_i;
    end else begin
      if (count_evt_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
      if (disc_evt_i)                 sticky_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fcm_mon.sv
module fcm_mon
  import fcm_pkg::*;
#(
  parameter int unsigned CAR_THR  = 480,
  parameter int unsigned IDLE_THR = 28000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rep_mode_i,
  input  logic              speed100_i,
  input  logic              disc_en_i,
  input  logic              bit_tick_i,
  input  logic              carrier_i,
  input  logic              carrier_start_i,
  input  logic              delim_ok_i,
  input  logic              frame_good_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              isolated_o
);
  localparam int unsigned DUR_MAX = CAR_THR + 1;
  localparam int unsigned DUR_W   = $clog2(DUR_MAX + 1);
  localparam int unsigned IDLE_W  = $clog2(IDLE_THR + 1);

  logic              active;
  logic              carrier_q, bad_q;
  logic              car_end, qual_false, qual_good, idle_done, count_evt, disc_evt;
  logic [DUR_W-1:0]  dur_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic [CNT_W-1:0]  cnt_q;
  logic              sticky_q;

  assign active = rep_mode_i && speed100_i && disc_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carrier_q <= 1'b0;
      bad_q     <= 1'b0;
    end else begin
      carrier_q <= carrier_i;
      if (carrier_start_i) bad_q <= !delim_ok_i;
    end
  end

  fcm_sat_timer #(.MAX(DUR_MAX)) u_dur (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (carrier_start_i),
    .inc_i (carrier_i && bit_tick_i),
    .cnt_o (dur_cnt)
  );

  fcm_sat_timer #(.MAX(IDLE_THR)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (carrier_i),
    .inc_i (bit_tick_i),
    .cnt_o (idle_cnt)
  );

  assign car_end    = carrier_q && !carrier_i;
  assign qual_false = car_end && bad_q && (dur_cnt > DUR_W'(CAR_THR));
  assign qual_good  = car_end && !bad_q && (dur_cnt >= DUR_W'(CAR_THR));
  assign idle_done  = !carrier_i && (idle_cnt >= IDLE_W'(IDLE_THR));
  assign count_evt  = active && carrier_start_i && !delim_ok_i;

  fcm_link_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .qual_false_i(qual_false),
    .qual_good_i (qual_good),
    .idle_done_i (idle_done),
    .frame_good_i(frame_good_i),
    .isolated_o  (isolated_o),
    .disc_evt_o  (disc_evt)
  );

  fcm_stat_reg u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_evt_i(count_evt),
    .disc_evt_i (disc_evt),
    .rd_i       (rd_i),
    .rd_data_o  (rd_data_o),
    .cnt_o      (cnt_q),
    .sticky_o   (sticky_q)
  );
endmodule

// File: rtl/fcm_mon_chk.sv
module fcm_mon_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rep_mode_i,
  input logic        speed100_i,
  input logic        disc_en_i,
  input logic        carrier_i,
  input logic        rd_i,
  input logic [15:0] rd_data_o,
  input logic        isolated_o,
  input logic [7:0]  cnt_q,
  input logic        sticky_q
);
  a_r2_iso_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isolated_o) |-> ($past(carrier_i, 2) && !$past(carrier_i)));

  a_r11_inactive_connected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(rep_mode_i && speed100_i && disc_en_i)) |-> !isolated_o);

  a_r9_cnt_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> (cnt_q >= $past(cnt_q)));

  a_r1_cnt_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> ((cnt_q - $past(cnt_q)) <= 8'd1));

  a_r8_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> (cnt_q <= 8'd1));

  a_r7_word_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> (rd_data_o == {$past(sticky_q), 7'd0, $past(cnt_q)}));

  a_r10_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(rd_i) && $past(sticky_q)) |-> sticky_q);
endmodule

bind fcm_mon fcm_mon_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rep_mode_i(rep_mode_i),
  .speed100_i(speed100_i),
  .disc_en_i (disc_en_i),
  .carrier_i (carrier_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .isolated_o(isolated_o),
  .cnt_q     (cnt_q),
  .sticky_q  (sticky_q)
);

// File: tb/fcm_mon_tb.sv
module fcm_mon_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rep = 1'b1, spd = 1'b1, en = 1'b1, tick = 1'b1;
  logic car = 1'b0, start = 1'b0, ok = 1'b0, fg = 1'b0, rd = 1'b0;
  logic [15:0] rdata;
  logic        iso;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  fcm_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rep_mode_i(rep), .speed100_i(spd),
    .disc_en_i(en), .bit_tick_i(tick), .carrier_i(car),
    .carrier_start_i(start), .delim_ok_i(ok), .frame_good_i(fg),
    .rd_i(rd), .rd_data_o(rdata), .isolated_o(iso)
  );

  // kind[18:17]: 0 false carrier, 1 good carrier, 2 good frame; len[16:1]; exp_iso[0]
  localparam logic [18:0] VEC [11] = '{
    {2'd0, 16'd600, 1'b0}, {2'd0, 16'd600, 1'b1}, {2'd1, 16'd100, 1'b1},
    {2'd1, 16'd600, 1'b0}, {2'd0, 16'd600, 1'b0}, {2'd2, 16'd0,   1'b0},
    {2'd0, 16'd600, 1'b0}, {2'd0, 16'd100, 1'b0}, {2'd0, 16'd600, 1'b1},
    {2'd0, 16'd100, 1'b1}, {2'd1, 16'd600, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic carrier(input logic good, input int len);
    @(negedge clk); car = 1'b1; start = 1'b1; ok = good;
    @(negedge clk); start = 1'b0; ok = 1'b0;
    repeat (len - 1) @(negedge clk);
    car = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame();
    @(negedge clk); fg = 1'b1;
    @(negedge clk); fg = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] w);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    w = rdata;
  endtask

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    chk("R12 iso after reset", {15'd0, iso}, 16'd0);
    chk("R12 word after reset", rdata, 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      case (VEC[i][18:17])
        2'd0: carrier(1'b0, int'(VEC[i][16:1]));
        2'd1: carrier(1'b1, int'(VEC[i][16:1]));
        default: frame();
      endcase
      chk($sformatf("R2/R4/R5 vector %0d iso", i), {15'd0, iso}, {15'd0, VEC[i][0]});
    end
    read_word(w); chk("R1/R7/R10 word after table", w, 16'h8007);
    read_word(w); chk("R8 cleared by read", w, 16'h0000);

    carrier(1'b0, 481); carrier(1'b0, 481);
    chk("R3 duration 480 not qualifying", {15'd0, iso}, 16'd0);
    carrier(1'b0, 482); carrier(1'b0, 482);
    chk("R3 duration 481 qualifies", {15'd0, iso}, 16'd1);
    carrier(1'b1, 480);
    chk("R5 good 479 keeps isolated", {15'd0, iso}, 16'd1);
    carrier(1'b1, 481);
    chk("R5 good 480 reconnects", {15'd0, iso}, 16'd0);
    carrier(1'b1, 600);
    read_word(w); chk("R1 good delimiters not counted", w, 16'h8004);

    carrier(1'b0, 600); carrier(1'b0, 600);
    chk("R6 isolated before idle", {15'd0, iso}, 16'd1);
    repeat (27000) @(negedge clk);
    chk("R6 still isolated at 27000 idle", {15'd0, iso}, 16'd1);
    repeat (1100) @(negedge clk);
    chk("R6 idle reconnect", {15'd0, iso}, 16'd0);
    read_word(w); chk("R10 flag held across reconnect", w, 16'h8002);

    @(negedge clk); rd = 1'b1; car = 1'b1; start = 1'b1; ok = 1'b0;
    @(negedge clk); rd = 1'b0; car = 1'b0; start = 1'b0;
    chk("R8 same-cycle event excluded", rdata, 16'h0000);
    @(negedge clk);
    read_word(w); chk("R8 same-cycle event counted after clear", w, 16'h0001);

    for (int k = 0; k < 260; k++) carrier(1'b0, 2);
    read_word(w); chk("R9 saturates at 255", w, 16'h00FF);

    en = 1'b0;
    carrier(1'b0, 600); carrier(1'b0, 600);
    chk("R11 disabled no isolation", {15'd0, iso}, 16'd0);
    read_word(w); chk("R11 disabled no counting", w, 16'h0000);
    en = 1'b1;
    carrier(1'b0, 600); carrier(1'b0, 600);
    chk("R11 setup isolated", {15'd0, iso}, 16'd1);
    @(negedge clk); spd = 1'b0;
    @(negedge clk);
    chk("R11 10M forces connect", {15'd0, iso}, 16'd0);
    spd = 1'b1;
    carrier(1'b0, 600);
    chk("R11 strike dropped when inactive", {15'd0, iso}, 16'd0);
    read_word(w); chk("R10 flag and count", w, 16'h8003);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule